// File: doc/BRIEF.md
# Paged Effective Address Generator

This block turns a 12-bit instruction word and the current program counter into the effective memory address of the operand, for a single-accumulator machine whose memory is split into fixed 128-word pages. The direct address is assembled by concatenation alone. The 7-bit word offset from the instruction goes either into page zero or into the page that holds the program counter. No adder takes part in this step.

When the instruction's indirect flag is set, the block reads the word at the direct address through a synchronous memory port and uses that word as the effective address. Eight low words of page zero act as self-advancing pointers. When one of them is reached indirectly, the block reads it, writes back the value plus one, and uses the incremented value. A controller raises `start` for one cycle and later receives the result together with a one-cycle `done` strobe.

Top module: `paged_ea_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge and on the cycle after it, `done`, `mem_rd` and `mem_wr` are 0.
- R2: The offset is instruction bits [6:0]. The page-select flag is bit 7 and the indirect flag is bit 8. When bit 7 is 0, the direct address is `{5'b0, instr[6:0]}`.
- R3: When bit 7 is 1, the direct address is `{pc[11:7], instr[6:0]}`. Program counter bits [6:0] never affect it.
- R4: Instruction bits [11:9] have no effect on the address, the timing or the memory traffic.
- R5: With bit 8 clear, `ea` equals the direct address and `done` rises one cycle after the `start` edge, with no memory access.
- R6: With bit 8 set and a direct address outside 8..15, the block issues exactly one read of the direct address and no write. `ea` equals the word that was read, and `done` rises three cycles after the `start` edge.
- R7: With bit 8 set and a direct address in 8..15, the block reads the word there and writes the word plus one back to the same address. `ea` equals that incremented value, and `done` rises four cycles after the `start` edge. Writes only ever target 8..15.
- R8: The pointer increment wraps modulo 4096, so 0xFFF becomes 0x000.
- R9: The increment depends only on the direct address. A current-page access with offset 8..15 on a nonzero page does not increment.
- R10: While an operation is in progress, `start` and changes on `instr` and `pc` are ignored.
- R11: `done` lasts exactly one cycle, `mem_rd` and `mem_wr` are never high together, and each read is followed by a cycle with no memory strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an address computation (sampled when idle) |
| instr | input | 12 | Instruction word |
| pc | input | 12 | Current program counter |
| mem_addr | output | 12 | Memory address |
| mem_rd | output | 1 | Read strobe; data valid on `mem_rdata` the following cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 12 | Write data |
| mem_rdata | input | 12 | Read data |
| ea | output | 12 | Effective address, valid when `done` is high |
| done | output | 1 | One-cycle completion strobe |

## Verification
On every cycle, assertions check that the two memory strobes never overlap, that `done` never lasts two cycles, and that each read is followed by a quiet cycle. They also check that every write hits the pointer window with the previously read word plus one, and that a write is always followed by `done`. Whether the page was selected correctly, whether opcode bits and busy-time `start` pulses are truly ignored, and the exact completion latency of each path can only be shown by the bench. It compares `ea`, cycle counts, read and write counts, and the memory contents after each operation against a shadow model, using random and directed instructions.

// File: rtl/paged_ea_pkg.sv
// Package: shared constants and the sequencer state type for the
// paged effective address generator.
package paged_ea_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_WAIT = 2'd2,
        ST_WBACK = 2'd3
    } ea_state_t;
endpackage

// File: rtl/ea_page_select.sv
// ea_page_select: forms the direct operand address by concatenation.
// Assumes the offset occupies the low OFS_W bits of the instruction and
// the page-select flag sits directly above it. No arithmetic is used.
module ea_page_select #(
    parameter int WORD_W = 12,
    parameter int OFS_W  = 7
) (
    input  logic [WORD_W-1:0] instr,
    input  logic [WORD_W-1:0] pc,
    output logic [WORD_W-1:0] direct_addr
);
    localparam int PAGE_W = WORD_W - OFS_W;

    logic [PAGE_W-1:0] page_bits;

    // Choose page zero or the program counter's page.
    always_comb begin
        page_bits = instr[OFS_W] ? pc[WORD_W-1:OFS_W] : '0;
        direct_addr = {page_bits, instr[OFS_W-1:0]};
    end
endmodule

// File: rtl/ea_ptr_step.sv
// ea_ptr_step: decides whether a direct address lies in the
// self-advancing pointer window and supplies the advanced pointer.
// Assumes WIN_LO <= WIN_HI and both fit in WORD_W bits.
module ea_ptr_step #(
    parameter int WORD_W = 12,
    parameter int WIN_LO = 8,
    parameter int WIN_HI = 15
) (
    input  logic [WORD_W-1:0] direct_addr,
    input  logic [WORD_W-1:0] ptr_word,
    output logic              in_window,
    output logic [WORD_W-1:0] ptr_next
);
    localparam logic [WORD_W-1:0] LO = WORD_W'(WIN_LO);
    localparam logic [WORD_W-1:0] HI = WORD_W'(WIN_HI);

    // Window compare and modulo-2^WORD_W increment.
    always_comb begin
        in_window = (direct_addr >= LO) && (direct_addr <= HI);
        ptr_next  = ptr_word + WORD_W'(1);
    end
endmodule

// File: rtl/paged_ea_gen.sv
// paged_ea_gen: sequences direct, indirect and self-advancing indirect
// effective address computation. Assumes a synchronous memory whose read
// data is valid one cycle after mem_rd and which writes on mem_wr.
module paged_ea_gen #(
    parameter int WORD_W = 12,
    parameter int OFS_W  = 7,
    parameter int WIN_LO = 8,
    parameter int WIN_HI = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] instr,
    input  logic [WORD_W-1:0] pc,
    output logic [WORD_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] ea,
    output logic              done
);
    import paged_ea_pkg::*;

    localparam int IND_BIT = OFS_W + 1;
    localparam int OPC_W   = WORD_W - OFS_W - 2;
    localparam logic [WORD_W-1:0] LO = WORD_W'(WIN_LO);
    localparam logic [WORD_W-1:0] HI = WORD_W'(WIN_HI);

    ea_state_t         state;
    logic [WORD_W-1:0] direct_addr;
    logic [WORD_W-1:0] addr_q;
    logic [WORD_W-1:0] wdata_q;
    logic              in_window;
    logic [WORD_W-1:0] ptr_next;
    logic [OPC_W-1:0]  opcode_unused;
    logic [OFS_W-1:0]  pc_low_unused;

    assign opcode_unused = instr[WORD_W-1:IND_BIT+1];
    assign pc_low_unused = pc[OFS_W-1:0];

    ea_page_select #(.WORD_W(WORD_W), .OFS_W(OFS_W)) u_page (
        .instr       (instr),
        .pc          (pc),
        .direct_addr (direct_addr)
    );

    ea_ptr_step #(.WORD_W(WORD_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_step (
        .direct_addr (addr_q),
        .ptr_word    (mem_rdata),
        .in_window   (in_window),
        .ptr_next    (ptr_next)
    );

    // Sequencer: latch the direct address, fetch, write back, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            ea      <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    addr_q <= direct_addr;
                    if (instr[IND_BIT]) begin
                        state <= ST_READ;
                    end else begin
                        ea   <= direct_addr;
                        done <= 1'b1;
                    end
                end
                ST_READ: state <= ST_WAIT;
                ST_WAIT: if (in_window) begin
                    wdata_q <= ptr_next;
                    state   <= ST_WBACK;
                end else begin
                    ea    <= mem_rdata;
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
                default: begin
                    ea    <= wdata_q;
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Memory strobes follow the sequencer state.
    always_comb begin
        mem_addr  = addr_q;
        mem_rd    = (state == ST_READ);
        mem_wr    = (state == ST_WBACK);
        mem_wdata = wdata_q;
    end

    // R11
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R11
    rd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (!mem_rd && !mem_wr));
    // R7
    wr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_addr >= LO && mem_addr <= HI));
    // R8
    wr_plus_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_wdata == WORD_W'($past(mem_rdata) + WORD_W'(1))));
    // R7
    wr_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> (done && ea == $past(mem_wdata)));
endmodule

// File: tb/paged_ea_gen_test.sv
module paged_ea_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] instr = '0;
    logic [11:0] pc = '0;
    logic [11:0] mem_addr, mem_wdata, ea;
    logic [11:0] mem_rdata = '0;
    logic        mem_rd, mem_wr, done;

    logic [11:0] mem   [4096];
    logic [11:0] model [4096];
    int rd_count = 0;
    int wr_count = 0;
    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    paged_ea_gen uut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pc(pc),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ea(ea), .done(done)
    );

    // Synchronous memory model with one-cycle read latency.
    always @(posedge clk) begin
        if (mem_wr) begin
            mem[mem_addr] <= mem_wdata;
            wr_count <= wr_count + 1;
        end
        if (mem_rd) begin
            mem_rdata <= mem[mem_addr];
            rd_count <= rd_count + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [11:0] direct_of(input logic [11:0] ins, input logic [11:0] p);
        return ins[7] ? {p[11:7], ins[6:0]} : {5'b0, ins[6:0]};
    endfunction

    // One operation: compute expectations, drive, wait, compare.
    task automatic run(input logic [11:0] ins, input logic [11:0] p,
                       input bit poke, input string req);
        logic [11:0] dir, exp_ea;
        bit ind, win, got;
        int exp_cyc, cyc, wr0, rd0;
        dir = direct_of(ins, p);
        ind = ins[8];
        win = (dir >= 12'd8) && (dir <= 12'd15);
        if (!ind) begin
            exp_ea = dir; exp_cyc = 1;
        end else if (win) begin
            exp_ea = model[dir] + 12'd1; model[dir] = exp_ea; exp_cyc = 4;
        end else begin
            exp_ea = model[dir]; exp_cyc = 3;
        end
        wr0 = wr_count; rd0 = rd_count;
        @(negedge clk);
        instr = ins; pc = p; start = 1'b1;
        cyc = 0; got = 0;
        while (!got && cyc < 20) begin
            @(negedge clk);
            cyc++;
            if (poke && ind && cyc == 1) begin
                instr = ~ins; pc = ~p;
            end else begin
                start = 1'b0;
            end
            if (done) got = 1;
        end
        start = 1'b0;
        chk(got, req, "done seen", int'(got), 1);
        chk(ea == exp_ea, req, "ea", int'(ea), int'(exp_ea));
        chk(cyc == exp_cyc, req, "latency", cyc, exp_cyc);
        chk(rd_count - rd0 == (ind ? 1 : 0), req, "reads", rd_count - rd0, ind ? 1 : 0);
        chk(wr_count - wr0 == ((ind && win) ? 1 : 0), req, "writes",
            wr_count - wr0, (ind && win) ? 1 : 0);
        if (ind && win)
            chk(mem[dir] == model[dir], req, "pointer word", int'(mem[dir]), int'(model[dir]));
        @(negedge clk);
        chk(!done, "R11", "done pulse width", int'(done), 0);
    endtask

    initial begin
        #(8 * 200000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 4096; i++) begin
            mem[i] = 12'((i * 37 + 5) & 12'hFFF);
            model[i] = mem[i];
        end
        mem[9] = 12'hFFF; model[9] = 12'hFFF;
        mem[12'h08C] = 12'h5A5; model[12'h08C] = 12'h5A5;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!done && !mem_rd && !mem_wr, "R1", "strobes in reset",
            {done, mem_rd, mem_wr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !mem_rd && !mem_wr, "R1", "strobes after reset",
            {done, mem_rd, mem_wr}, 0);

        // R2, R5: direct page zero
        run(12'b000_0_0_0101010, 12'hABC, 0, "R2");
        // R3, R5: direct current page, pc low bits irrelevant
        run(12'b000_0_1_0001111, 12'b10110_1111111, 0, "R3");
        run(12'b000_0_1_0001111, 12'b10110_0000000, 0, "R3");
        // R4: opcode bits do not matter
        run(12'b111_0_1_1110000, 12'h3C5, 0, "R4");
        run(12'b101_1_0_0100000, 12'h3C5, 0, "R4");
        // R6: plain indirect
        run(12'b010_1_0_1000000, 12'h000, 0, "R6");
        // R7: self-advancing pointer
        run(12'b000_1_0_0001000, 12'h777, 0, "R7");
        run(12'b000_1_0_0001111, 12'h777, 0, "R7");
        run(12'b000_1_0_0001000, 12'h777, 0, "R7");
        // R8: wrap of 0xFFF
        run(12'b000_1_0_0001001, 12'h000, 0, "R8");
        // R9: current page offset 12 on page 1 does not advance
        run(12'b000_1_1_0001100, 12'h0A0, 0, "R9");
        // R7: current page on page zero lands in the window
        run(12'b000_1_1_0001010, 12'h040, 0, "R7");
        // R10: start and inputs ignored while busy
        run(12'b000_1_0_0001011, 12'h123, 1, "R10");
        run(12'b000_1_0_1010101, 12'h123, 1, "R10");

        // Random mix with frequent window hits.
        for (int k = 0; k < 300; k++) begin
            logic [11:0] ri, rp;
            ri = 12'($urandom);
            rp = 12'($urandom);
            if (($urandom % 4) == 0) begin
                ri[8] = 1'b1; ri[7] = 1'b0; ri[6:0] = 7'(8 + ($urandom % 8));
            end
            run(ri, rp, ($urandom % 3) == 0, "R2 R3 R5 R6 R7");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule